// File: doc/BRIEF.md
# SDRAM Refresh Command Sequencer

This block sits inside an SDRAM memory controller and turns refresh work into command-pin activity. When the refresh timer elsewhere raises a request with a burst count, the sequencer closes every open bank with one precharge-all command. It waits a programmed precharge gap and then issues the requested number of auto-refresh commands. After each auto-refresh it holds off further commands for a programmed refresh-cycle lockout. A busy flag tells the rest of the controller to keep its own commands off the pins for the whole sequence.

Two configuration bits select the refresh style. With the enable bit set and the mode bit clear, the block serves burst requests. With both bits set, it precharges all banks, enters self-refresh by driving the refresh encoding with clock-enable low, and keeps clock-enable low until the enable bit is cleared. It then raises clock-enable and applies one lockout before returning to idle. Command pins are registered, so they change one clock after the internal state that selects them.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, the pins show deselect (`{cs_n,ras_n,cas_n,we_n}` = 1111), `cke` = 1, `a10` = 0, and `busy` = 0 and `req_ack` = 0.
- R2: With `refresh_en`=1, `mode_self`=0, `req_valid`=1 and `req_count`≠0, a sequence starts. Its first pin cycle is precharge-all (0010, `a10`=1, `cke`=1). `req_ack` is high in that cycle only, and `a10` is low in every other cycle.
- R3: `trp_code` 0..3 gives a precharge-to-refresh distance d of 1, 2, 3 or 4 cycles. The first auto-refresh appears d cycles after the precharge-all, and the d−1 cycles between them carry NOP (0111, `cke`=1).
- R4: `trc_code` 0..3 gives a lockout of 2, 3, 5 or 8 cycles. Each auto-refresh is followed by exactly that many NOP cycles before the next command.
- R5: A burst issues exactly `req_count` auto-refresh commands (0001, `cke`=1) and only one precharge-all.
- R6: `busy` is high from the precharge-all cycle through the last lockout cycle. When `busy` is low, the pins show deselect with `cke`=1.
- R7: A request with `req_count`=0 is ignored: no acknowledge, no busy and no command.
- R8: While `refresh_en`=0, requests and `mode_self` have no effect on the pins.
- R9: With `refresh_en`=1 and `mode_self`=1, the block issues a precharge-all, the R3 gap, then one self-refresh entry cycle (0001 with `cke`=0). After that it shows deselect with `cke`=0 for as long as `refresh_en` stays high. `req_ack` stays low throughout.
- R10: When `refresh_en` clears during self-refresh, `cke` returns high within two cycles. The R4 lockout of NOP cycles follows, and then the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| refresh_en | input | 1 | Refresh enable bit |
| mode_self | input | 1 | 1 selects self-refresh, 0 selects auto-refresh bursts |
| req_valid | input | 1 | Refresh burst request from the refresh timer |
| req_count | input | CNT_W | Number of auto-refresh commands in the burst |
| trp_code | input | 2 | Precharge-gap code |
| trc_code | input | 2 | Refresh-cycle lockout code |
| req_ack | output | 1 | Request taken; high in the precharge-all cycle |
| busy | output | 1 | Sequencer owns the command pins |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| a10 | output | 1 | Address bit 10; selects all banks on precharge |

## Verification
The hardest cases to reach are the exit from self-refresh and the last refresh of a long burst under the longest lockout. In both, the busy edge depends on a timer and a burst counter expiring in the same cycle. The bench sweeps every gap code against every lockout code for several burst lengths, including the largest count the port allows. It runs self-refresh under all sixteen code pairs and clears the enable at a fixed cycle inside the hold, so the exit lockout always starts from a known point.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  localparam int DLY_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PALL   = 3'd1,
    ST_GAP    = 3'd2,
    ST_AREF   = 3'd3,
    ST_LOCK   = 3'd4,
    ST_SENTRY = 3'd5,
    ST_SHOLD  = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_PALL  = 2'd2,
    CMD_REF   = 2'd3
  } cmd_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cke;
    logic a10;
  } pins_t;

  // precharge-to-refresh distance in cycles
  function automatic logic [DLY_W-1:0] gap_cycles(input logic [1:0] code);
    gap_cycles = DLY_W'({2'b00, code}) + DLY_W'(1);
  endfunction

  // lockout after each refresh command in cycles
  function automatic logic [DLY_W-1:0] trc_cycles(input logic [1:0] code);
    case (code)
      2'd0:    trc_cycles = DLY_W'(2);
      2'd1:    trc_cycles = DLY_W'(3);
      2'd2:    trc_cycles = DLY_W'(5);
      default: trc_cycles = DLY_W'(8);
    endcase
  endfunction

  function automatic pins_t cmd_pins(input cmd_t c, input logic cke_v);
    pins_t p;
    p.cke = cke_v;
    p.a10 = 1'b0;
    case (c)
      CMD_NOP:  {p.cs_n, p.ras_n, p.cas_n, p.we_n} = 4'b0111;
      CMD_PALL: begin
        {p.cs_n, p.ras_n, p.cas_n, p.we_n} = 4'b0010;
        p.a10 = 1'b1;
      end
      CMD_REF:  {p.cs_n, p.ras_n, p.cas_n, p.we_n} = 4'b0001;
      default:  {p.cs_n, p.ras_n, p.cas_n, p.we_n} = 4'b1111;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int W = sdram_ref_pkg::DLY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/sdram_ref_burst.sv
module sdram_ref_burst #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         more
);

  logic [W-1:0] left_q;
  logic [W-1:0] left_d;
  logic         left_en;

  always_comb begin
    left_en = load || (dec && (left_q != '0));
    if (load) left_d = load_val;
    else      left_d = left_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign more = (left_q != '0);

endmodule

// File: rtl/sdram_ref_fsm.sv
module sdram_ref_fsm
  import sdram_ref_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_en,
  input  logic             mode_self,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_count,
  input  logic [1:0]       trp_code,
  input  logic [1:0]       trc_code,
  input  logic             tmr_last,
  input  logic             burst_more,
  output seq_state_t       state,
  output logic             self_path,
  output logic             tmr_load,
  output logic [DLY_W-1:0] tmr_val,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dec
);

  seq_state_t       state_q, state_d;
  logic             self_q, self_d;
  logic             take;
  logic [DLY_W-1:0] gap_len;
  seq_state_t       after_gap;

  assign gap_len   = gap_cycles(trp_code);
  assign after_gap = self_q ? ST_SENTRY : ST_AREF;

  always_comb begin
    state_d  = state_q;
    self_d   = self_q;
    take     = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (refresh_en && mode_self) begin
          take     = 1'b1;
          self_d   = 1'b1;
          cnt_load = 1'b1;
          state_d  = ST_PALL;
        end else if (refresh_en && req_valid && (req_count != '0)) begin
          take     = 1'b1;
          self_d   = 1'b0;
          cnt_load = 1'b1;
          cnt_val  = req_count;
          state_d  = ST_PALL;
        end
      end
      ST_PALL: begin
        if (gap_len == DLY_W'(1)) begin
          state_d = after_gap;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = gap_len - DLY_W'(1);
          state_d  = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_last) state_d = after_gap;
      end
      ST_AREF: begin
        tmr_load = 1'b1;
        tmr_val  = trc_cycles(trc_code);
        cnt_dec  = 1'b1;
        state_d  = ST_LOCK;
      end
      ST_LOCK: begin
        if (tmr_last) state_d = burst_more ? ST_AREF : ST_IDLE;
      end
      ST_SENTRY: begin
        state_d = ST_SHOLD;
      end
      ST_SHOLD: begin
        if (!refresh_en) begin
          tmr_load = 1'b1;
          tmr_val  = trc_cycles(trc_code);
          state_d  = ST_LOCK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    self_q <= 1'b0;
    else if (take) self_q <= self_d;
  end

  assign state     = state_q;
  assign self_path = self_q;

endmodule

// File: rtl/sdram_ref_cmd_out.sv
module sdram_ref_cmd_out
  import sdram_ref_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state,
  input  logic       self_path,
  output pins_t      pins,
  output logic       ack,
  output logic       busy
);

  cmd_t  cmd;
  logic  cke_d;
  pins_t pins_d;
  logic  ack_d, busy_d;

  always_comb begin
    cke_d = 1'b1;
    case (state)
      ST_PALL:   cmd = CMD_PALL;
      ST_GAP:    cmd = CMD_NOP;
      ST_AREF:   cmd = CMD_REF;
      ST_LOCK:   cmd = CMD_NOP;
      ST_SENTRY: begin cmd = CMD_REF;   cke_d = 1'b0; end
      ST_SHOLD:  begin cmd = CMD_DESEL; cke_d = 1'b0; end
      default:   cmd = CMD_DESEL;
    endcase
    pins_d = cmd_pins(cmd, cke_d);
    ack_d  = (state == ST_PALL) && !self_path;
    busy_d = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= cmd_pins(CMD_DESEL, 1'b1);
      ack  <= 1'b0;
      busy <= 1'b0;
    end else begin
      pins <= pins_d;
      ack  <= ack_d;
      busy <= busy_d;
    end
  end

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_ref_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_en,
  input  logic             mode_self,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_count,
  input  logic [1:0]       trp_code,
  input  logic [1:0]       trc_code,
  output logic             req_ack,
  output logic             busy,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             cke,
  output logic             a10
);

  logic rst_meta_n, rst_core_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  seq_state_t       state;
  logic             self_path;
  logic             tmr_load, tmr_last;
  logic [DLY_W-1:0] tmr_val;
  logic             cnt_load, cnt_dec, burst_more;
  logic [CNT_W-1:0] cnt_val;
  pins_t            pins;

  sdram_ref_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .refresh_en (refresh_en),
    .mode_self  (mode_self),
    .req_valid  (req_valid),
    .req_count  (req_count),
    .trp_code   (trp_code),
    .trc_code   (trc_code),
    .tmr_last   (tmr_last),
    .burst_more (burst_more),
    .state      (state),
    .self_path  (self_path),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cnt_load   (cnt_load),
    .cnt_val    (cnt_val),
    .cnt_dec    (cnt_dec)
  );

  sdram_ref_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sdram_ref_burst #(.W(CNT_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .more     (burst_more)
  );

  sdram_ref_cmd_out u_out (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .state     (state),
    .self_path (self_path),
    .pins      (pins),
    .ack       (req_ack),
    .busy      (busy)
  );

  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;
  assign cke   = pins.cke;
  assign a10   = pins.a10;

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ack,
  input logic busy,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic a10
);

  logic is_pall, is_refenc, is_nop, is_aref;

  assign is_pall   = !cs_n && !ras_n &&  cas_n && !we_n && a10;
  assign is_refenc = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_nop    = !cs_n &&  ras_n &&  cas_n &&  we_n;
  assign is_aref   = is_refenc && cke;

  p_ack_is_pall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> is_pall);

  p_ack_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_ref_then_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |=> is_nop);

  p_ref_lock_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_aref) |-> !is_aref);

  p_busy_starts_pall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> is_pall);

  p_idle_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && cke));

  p_cke_fall_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (is_refenc && busy));

  p_cke_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$fell(cke)) |-> cs_n);

  p_cke_rise_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (is_nop && busy));

endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_ack (req_ack),
  .busy    (busy),
  .cs_n    (cs_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .cke     (cke),
  .a10     (a10)
);

// File: tb/tb_sdram_refresh_seq.sv
module tb_sdram_refresh_seq;

  localparam int CNT_W = 3;

  // {ack,busy,cs_n,ras_n,cas_n,we_n,cke,a10}
  localparam logic [7:0] V_DESEL  = 8'b0_0_1111_1_0;
  localparam logic [7:0] V_NOP    = 8'b0_1_0111_1_0;
  localparam logic [7:0] V_PALL_A = 8'b1_1_0010_1_1;
  localparam logic [7:0] V_PALL_S = 8'b0_1_0010_1_1;
  localparam logic [7:0] V_AREF   = 8'b0_1_0001_1_0;
  localparam logic [7:0] V_SREF   = 8'b0_1_0001_0_0;
  localparam logic [7:0] V_SHOLD  = 8'b0_1_1111_0_0;

  logic clk = 1'b0;
  logic rst_n;
  logic refresh_en, mode_self, req_valid;
  logic [CNT_W-1:0] req_count;
  logic [1:0] trp_code, trc_code;
  logic req_ack, busy, cs_n, ras_n, cas_n, we_n, cke, a10;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdram_refresh_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .mode_self(mode_self),
    .req_valid(req_valid), .req_count(req_count), .trp_code(trp_code),
    .trc_code(trc_code), .req_ack(req_ack), .busy(busy), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .a10(a10)
  );

  function automatic logic [7:0] obs();
    return {req_ack, busy, cs_n, ras_n, cas_n, we_n, cke, a10};
  endfunction

  function automatic int lock_len(input int code);
    case (code)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic run_auto(input int trp, input int trc, input int n);
    int d, t, total, arefs, palls, bad_i;
    logic [7:0] bad_a, bad_e, o, e;
    string tag;
    d = trp + 1;
    t = lock_len(trc);
    total = d + n * (t + 1);
    @(negedge clk);
    refresh_en = 1'b1; mode_self = 1'b0;
    trp_code = 2'(trp); trc_code = 2'(trc);
    req_count = CNT_W'(n); req_valid = 1'b1;
    for (int w = 0; w < 10 && !req_ack; w++) @(negedge clk);
    req_valid = 1'b0;
    arefs = 0; palls = 0; bad_i = -1; bad_a = '0; bad_e = '0;
    for (int i = 0; i <= total + 1; i++) begin
      o = obs();
      if (i == 0) e = V_PALL_A;
      else if (i < d) e = V_NOP;
      else if (i < total) e = (((i - d) % (t + 1)) == 0) ? V_AREF : V_NOP;
      else e = V_DESEL;
      if (o[5:0] == V_AREF[5:0]) arefs++;
      if (o[0]) palls++;
      if (o !== e && bad_i < 0) begin bad_i = i; bad_a = o; bad_e = e; end
      @(negedge clk);
    end
    if (bad_i < 0) tag = "R3";
    else if (bad_i == 0) tag = "R2";
    else if (bad_i < d) tag = "R3";
    else if (bad_i < total) tag = (((bad_i - d) % (t + 1)) == 0) ? "R5" : "R4";
    else tag = "R6";
    check(bad_i < 0, tag, bad_a, bad_e,
          $sformatf("auto trp=%0d trc=%0d n=%0d cycle=%0d", trp, trc, n, bad_i));
    check(arefs == n && palls == 1, "R5", 8'(arefs), 8'(n),
          $sformatf("refresh count (pall=%0d) trp=%0d trc=%0d", palls, trp, trc));
  endtask

  task automatic run_self(input int trp, input int trc);
    int d, t, m, bad_i;
    logic [7:0] bad_a, bad_e, o, e;
    d = trp + 1;
    t = lock_len(trc);
    m = d + 4;
    @(negedge clk);
    trp_code = 2'(trp); trc_code = 2'(trc);
    mode_self = 1'b1; refresh_en = 1'b1;
    for (int w = 0; w < 10 && !a10; w++) @(negedge clk);
    bad_i = -1; bad_a = '0; bad_e = '0;
    for (int i = 0; i <= m + t + 3; i++) begin
      o = obs();
      if (i == 0) e = V_PALL_S;
      else if (i < d) e = V_NOP;
      else if (i == d) e = V_SREF;
      else if (i <= m + 1) e = V_SHOLD;
      else if (i <= m + 1 + t) e = V_NOP;
      else e = V_DESEL;
      if (o !== e && bad_i < 0) begin bad_i = i; bad_a = o; bad_e = e; end
      if (i == m) refresh_en = 1'b0;
      @(negedge clk);
    end
    mode_self = 1'b0;
    check(bad_i < 0, (bad_i < 0 || bad_i <= m + 1) ? "R9" : "R10", bad_a, bad_e,
          $sformatf("self trp=%0d trc=%0d cycle=%0d", trp, trc, bad_i));
  endtask

  task automatic run_quiet(input string req, input string what);
    int bad;
    logic [7:0] last_o;
    bad = 0; last_o = V_DESEL;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (obs() !== V_DESEL && bad == 0) begin bad = 1; last_o = obs(); end
    end
    check(bad == 0, req, last_o, V_DESEL, what);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; refresh_en = 1'b0; mode_self = 1'b0; req_valid = 1'b0;
    req_count = '0; trp_code = '0; trc_code = '0;
    repeat (3) @(negedge clk);
    check(obs() === V_DESEL, "R1", obs(), V_DESEL, "during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(obs() === V_DESEL, "R1", obs(), V_DESEL, "after reset");

    // R7: zero-count request
    refresh_en = 1'b1; req_count = '0; req_valid = 1'b1;
    run_quiet("R7", "zero count request");
    req_valid = 1'b0;

    // R8: enable low, request and self mode present
    refresh_en = 1'b0; mode_self = 1'b1; req_count = 3'd3; req_valid = 1'b1;
    run_quiet("R8", "enable low");
    req_valid = 1'b0; mode_self = 1'b0;
    @(negedge clk);

    // R2..R6: full sweep of codes and burst lengths
    for (int trp = 0; trp < 4; trp++)
      for (int trc = 0; trc < 4; trc++)
        for (int n = 1; n <= 4; n++)
          run_auto(trp, trc, n);
    run_auto(3, 3, 7);
    run_auto(0, 0, 7);

    // R9, R10: self-refresh entry and exit
    for (int trp = 0; trp < 4; trp++)
      for (int trc = 0; trc < 4; trc++)
        run_self(trp, trc);

    // R6: idle after everything
    run_quiet("R6", "idle at end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule